// File: doc/BRIEF.md
# Receive Channel Router and Serializer

This block sits between four ADC sample streams and a bank of up to four complex downconverter channels. A 32-bit configuration word chooses, for every channel, which ADC feeds its in-phase input and which feeds its quadrature input. A single flag in the same word ties every quadrature input to zero instead, which suits a real-only front end. The routed pairs are registered and presented on per-channel buses. Here the channel stage is a pass-through, so the routed samples are the samples that get sent.

The same pairs are then sent, one 16-bit word at a time, over a valid/ready stream toward the host link. The channel-count field sets the length of each burst to 1, 2 or 4 complex channels. Within a burst, channel 0 goes first and each channel sends its in-phase word before its quadrature word.

The configuration and the ADC samples are captured only on a sample strobe that arrives while the stream is idle. A strobe that arrives during a burst is dropped and noted in a sticky overrun flag. An unusable configuration is noted in a sticky error flag.

Top module: `rxroute_top`

## Requirements
- R1: After an accepted strobe, channel c's in-phase bus (ch_i_bus bits 16c+15:16c) carries the sample of the ADC named by configuration bits 5+4c:4+4c. Code k selects ADC k, which is adc_bus bits 16k+15:16k. The bus updates one cycle after the strobe.
- R2: When configuration bit 3 is 0, channel c's quadrature bus (ch_q_bus bits 16c+15:16c) carries the sample of the ADC named by configuration bits 7+4c:6+4c. It uses the same code and timing as R1.
- R3: When configuration bit 3 is 1 at an accepted strobe, every quadrature bus is zero.
- R4: Configuration bits 2:0 give the channel count. The values 1, 2 and 4 produce bursts of 2, 4 and 8 words. The words go out in the order I0, Q0, I1, Q1, I2, Q2, I3, Q3, cut off at the burst length.
- R5: A channel count other than 1, 2 or 4, or a nonzero bit in configuration bits 31:20, raises cfg_err at an accepted strobe. An illegal count produces a 2-word burst, as if the count were 1. cfg_err stays high until reset.
- R6: While out_valid is high and out_ready is low, out_valid stays high and out_data keeps its value.
- R7: A strobe that arrives while out_valid is high is dropped. The channel buses and the burst in progress are unchanged, and ovr_flag rises the next cycle and stays high until reset.
- R8: The configuration and ADC samples are captured only at an accepted strobe. Changes to the inputs during a burst do not alter that burst.
- R9: After reset, out_valid, cfg_err and ovr_flag are low and all channel buses are zero.
- R10: out_valid rises one cycle after an accepted strobe, with word 0 on out_data. It falls one cycle after the handshake of the last word. A strobe is accepted in any cycle in which out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adc_bus | input | 64 | Four ADC samples, ADC k in bits 16k+15:16k |
| smp_stb | input | 1 | A new sample set is present |
| cfg_word | input | 32 | Routing, zero-Q and channel-count configuration |
| out_ready | input | 1 | The stream sink accepts a word |
| ch_i_bus | output | 64 | In-phase inputs for the four channels |
| ch_q_bus | output | 64 | Quadrature inputs for the four channels |
| out_valid | output | 1 | out_data holds a word |
| out_data | output | 16 | Serialized sample word |
| cfg_err | output | 1 | Sticky configuration error |
| ovr_flag | output | 1 | Sticky strobe overrun |

## Verification
The channel buses, out_valid and the first word are all due one clock after the strobe is accepted. Each further word is due one clock after a cycle in which out_valid and out_ready were both high. out_valid is due low one clock after the last such cycle, and both flags are due one clock after their cause. The bench drives inputs and samples outputs on the falling edge. The edge that falls between a drive and the next sample is therefore exactly the edge on which the result is due, and the bench counts handshakes itself to know which word is expected.

// File: rtl/rxroute_pkg.sv
package rxroute_pkg;
  // configuration word layout
  localparam int unsigned CFG_W   = 32;
  localparam int unsigned CNT_LSB = 0;
  localparam int unsigned CNT_W   = 3;
  localparam int unsigned ZQ_BIT  = 3;
  localparam int unsigned FLD_LSB = 4;

  // a channel count is usable when it is a nonzero power of two within range
  function automatic logic count_is_legal(input logic [CNT_W-1:0] code,
                                          input int unsigned max_ch);
    logic [CNT_W-1:0] m1;
    m1 = code - 1'b1;
    return (code != '0) && ((code & m1) == '0) && (int'(code) <= int'(max_ch));
  endfunction
endpackage

// File: rtl/rxroute_cfgdec.sv
module rxroute_cfgdec #(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned RSV_W  = 12,
  parameter int unsigned WCNT_W = 4
) (
  input  logic [rxroute_pkg::CNT_W-1:0] cnt_code,
  input  logic [RSV_W-1:0]              rsv_bits,
  output logic [WCNT_W-1:0]             n_words,
  output logic                          bad_cfg
);
  import rxroute_pkg::*;

  logic legal;

  always_comb begin
    legal   = count_is_legal(cnt_code, NUM_CH);
    // fallback to a single channel when the count is unusable
    n_words = legal ? WCNT_W'(2 * int'(cnt_code)) : WCNT_W'(2);
    bad_cfg = !legal || (rsv_bits != '0);
  end
endmodule

// File: rtl/rxroute_xbar.sv
module rxroute_xbar #(
  parameter int unsigned SMP_W   = 16,
  parameter int unsigned NUM_ADC = 4,
  parameter int unsigned NUM_CH  = 4,
  parameter int unsigned SEL_W   = 2
) (
  input  logic [NUM_ADC*SMP_W-1:0]  adc_bus,
  input  logic [NUM_CH*2*SEL_W-1:0] sel_fields,
  input  logic                      zero_q,
  output logic [NUM_CH*SMP_W-1:0]   i_bus,
  output logic [NUM_CH*SMP_W-1:0]   q_bus
);
  logic [SMP_W-1:0] adc_arr [NUM_ADC];

  always_comb begin
    for (int a = 0; a < int'(NUM_ADC); a++) begin
      adc_arr[a] = adc_bus[a*SMP_W +: SMP_W];
    end
  end

  for (genvar c = 0; c < int'(NUM_CH); c++) begin : g_ch
    logic [SEL_W-1:0] isel;
    logic [SEL_W-1:0] qsel;
    logic [SMP_W-1:0] ival;
    logic [SMP_W-1:0] qval;

    always_comb begin
      isel = sel_fields[c*2*SEL_W +: SEL_W];
      qsel = sel_fields[c*2*SEL_W+SEL_W +: SEL_W];
      ival = '0;
      qval = '0;
      for (int a = 0; a < int'(NUM_ADC); a++) begin
        if (int'(isel) == a) ival = adc_arr[a];
        if (int'(qsel) == a) qval = adc_arr[a];
      end
      if (zero_q) qval = '0;
    end

    assign i_bus[c*SMP_W +: SMP_W] = ival;
    assign q_bus[c*SMP_W +: SMP_W] = qval;
  end
endmodule

// File: rtl/rxroute_ser.sv
module rxroute_ser #(
  parameter int unsigned SMP_W  = 16,
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned WCNT_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [WCNT_W-1:0]        n_words_in,
  input  logic [NUM_CH*SMP_W-1:0]  i_bus,
  input  logic [NUM_CH*SMP_W-1:0]  q_bus,
  input  logic                     out_ready,
  output logic                     out_valid,
  output logic [SMP_W-1:0]         out_data
);
  logic              valid_q, valid_d;
  logic [WCNT_W-1:0] idx_q, idx_d;
  logic [WCNT_W-1:0] last_q, last_d;
  logic              step;

  assign step = valid_q && out_ready;

  always_comb begin
    valid_d = valid_q;
    idx_d   = idx_q;
    last_d  = last_q;
    if (load) begin
      valid_d = 1'b1;
      idx_d   = '0;
      last_d  = n_words_in - 1'b1;
    end else if (step) begin
      if (idx_q == last_q) valid_d = 1'b0;
      else                 idx_d   = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
      last_q  <= '0;
    end else begin
      valid_q <= valid_d;
      if (load || step) begin
        idx_q  <= idx_d;
        last_q <= last_d;
      end
    end
  end

  // word index: bit 0 picks I or Q, upper bits pick the channel
  always_comb begin
    out_data = '0;
    for (int c = 0; c < int'(NUM_CH); c++) begin
      if (int'(idx_q >> 1) == c) begin
        out_data = idx_q[0] ? q_bus[c*SMP_W +: SMP_W] : i_bus[c*SMP_W +: SMP_W];
      end
    end
  end

  assign out_valid = valid_q;
endmodule

// File: rtl/rxroute_top.sv
module rxroute_top #(
  parameter int unsigned SMP_W   = 16,
  parameter int unsigned NUM_ADC = 4,
  parameter int unsigned NUM_CH  = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_ADC*SMP_W-1:0]   adc_bus,
  input  logic                       smp_stb,
  input  logic [31:0]                cfg_word,
  input  logic                       out_ready,
  output logic [NUM_CH*SMP_W-1:0]    ch_i_bus,
  output logic [NUM_CH*SMP_W-1:0]    ch_q_bus,
  output logic                       out_valid,
  output logic [SMP_W-1:0]           out_data,
  output logic                       cfg_err,
  output logic                       ovr_flag
);
  import rxroute_pkg::*;

  localparam int unsigned SEL_W   = (NUM_ADC > 1) ? $clog2(NUM_ADC) : 1;
  localparam int unsigned FLD_W   = NUM_CH * 2 * SEL_W;
  localparam int unsigned RSV_LSB = FLD_LSB + FLD_W;
  localparam int unsigned RSV_W   = CFG_W - RSV_LSB;
  localparam int unsigned WCNT_W  = $clog2(2 * NUM_CH + 1);

  logic                    accept;
  logic                    drop;
  logic [WCNT_W-1:0]       n_words;
  logic                    bad_cfg;
  logic [NUM_CH*SMP_W-1:0] rt_i, rt_q;
  logic [NUM_CH*SMP_W-1:0] ch_i_q, ch_q_q;
  logic                    err_q, err_d;
  logic                    ovr_q, ovr_d;

  assign accept = smp_stb && !out_valid;
  assign drop   = smp_stb &&  out_valid;

  rxroute_cfgdec #(
    .NUM_CH (NUM_CH),
    .RSV_W  (RSV_W),
    .WCNT_W (WCNT_W)
  ) u_cfgdec (
    .cnt_code (cfg_word[CNT_LSB +: CNT_W]),
    .rsv_bits (cfg_word[RSV_LSB +: RSV_W]),
    .n_words  (n_words),
    .bad_cfg  (bad_cfg)
  );

  rxroute_xbar #(
    .SMP_W   (SMP_W),
    .NUM_ADC (NUM_ADC),
    .NUM_CH  (NUM_CH),
    .SEL_W   (SEL_W)
  ) u_xbar (
    .adc_bus    (adc_bus),
    .sel_fields (cfg_word[FLD_LSB +: FLD_W]),
    .zero_q     (cfg_word[ZQ_BIT]),
    .i_bus      (rt_i),
    .q_bus      (rt_q)
  );

  always_comb begin
    err_d = err_q || (accept && bad_cfg);
    ovr_d = ovr_q || drop;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ch_i_q <= '0;
      ch_q_q <= '0;
      err_q  <= 1'b0;
      ovr_q  <= 1'b0;
    end else begin
      if (accept) begin
        ch_i_q <= rt_i;
        ch_q_q <= rt_q;
      end
      err_q <= err_d;
      ovr_q <= ovr_d;
    end
  end

  rxroute_ser #(
    .SMP_W  (SMP_W),
    .NUM_CH (NUM_CH),
    .WCNT_W (WCNT_W)
  ) u_ser (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept),
    .n_words_in (n_words),
    .i_bus      (ch_i_q),
    .q_bus      (ch_q_q),
    .out_ready  (out_ready),
    .out_valid  (out_valid),
    .out_data   (out_data)
  );

  assign ch_i_bus = ch_i_q;
  assign ch_q_bus = ch_q_q;
  assign cfg_err  = err_q;
  assign ovr_flag = ovr_q;
endmodule

// File: rtl/rxroute_chk.sv
module rxroute_chk #(
  parameter int unsigned SMP_W  = 16,
  parameter int unsigned NUM_CH = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    smp_stb,
  input logic                    zq_req,
  input logic                    out_ready,
  input logic                    out_valid,
  input logic [SMP_W-1:0]        out_data,
  input logic [NUM_CH*SMP_W-1:0] ch_i_bus,
  input logic [NUM_CH*SMP_W-1:0] ch_q_bus,
  input logic                    cfg_err,
  input logic                    ovr_flag
);
  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R6

  AST_ZERO_Q: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !out_valid && zq_req) |=> (ch_q_bus == '0)); // R3

  AST_BURST_START: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && !out_valid) |=> out_valid); // R10

  AST_DROP_KEEPS_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_stb && out_valid) |=> ($stable(ch_i_bus) && $stable(ch_q_bus) && ovr_flag)); // R7

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_flag |=> ovr_flag); // R7

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> cfg_err); // R5

  AST_BUS_FROZEN_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> ($stable(ch_i_bus) && $stable(ch_q_bus))); // R8
endmodule

bind rxroute_top rxroute_chk #(
  .SMP_W  (SMP_W),
  .NUM_CH (NUM_CH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_stb   (smp_stb),
  .zq_req    (cfg_word[rxroute_pkg::ZQ_BIT]),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_data  (out_data),
  .ch_i_bus  (ch_i_bus),
  .ch_q_bus  (ch_q_bus),
  .cfg_err   (cfg_err),
  .ovr_flag  (ovr_flag)
);

// File: tb/rxroute_top_bench.sv
`timescale 1ns/1ps
module rxroute_top_bench;
  logic        clk;
  logic        rst_n;
  logic [63:0] adc_bus;
  logic        smp_stb;
  logic [31:0] cfg_word;
  logic        out_ready;
  logic [63:0] ch_i_bus;
  logic [63:0] ch_q_bus;
  logic        out_valid;
  logic [15:0] out_data;
  logic        cfg_err;
  logic        ovr_flag;

  int n_cmp;
  int n_bad;
  bit err_exp;
  bit ovr_exp;
  bit done;

  rxroute_top u_rxroute_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .adc_bus   (adc_bus),
    .smp_stb   (smp_stb),
    .cfg_word  (cfg_word),
    .out_ready (out_ready),
    .ch_i_bus  (ch_i_bus),
    .ch_q_bus  (ch_q_bus),
    .out_valid (out_valid),
    .out_data  (out_data),
    .cfg_err   (cfg_err),
    .ovr_flag  (ovr_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(input int cnt, input bit zq, input int pat);
    logic [31:0] w;
    w = '0;
    w[2:0] = 3'(cnt);
    w[3]   = zq;
    for (int c = 0; c < 4; c++) begin
      w[4+4*c +: 2] = 2'((pat + c) % 4);
      w[6+4*c +: 2] = 2'((pat / 4 + 3 * c + 1) % 4);
    end
    return w;
  endfunction

  function automatic logic [63:0] mk_adc(input int pat);
    logic [63:0] v;
    for (int a = 0; a < 4; a++) v[16*a +: 16] = 16'((a + 1) * 16'h1111 + pat * 16'h0103);
    return v;
  endfunction

  task automatic run_burst(input logic [31:0] cfg, input logic [63:0] adcv,
                           input int pat, input bit inject);
    logic [63:0] ei, eq;
    logic [15:0] ew [8];
    int cnt, nw, k, cyc;
    bit r, prev_r, injected;
    for (int c = 0; c < 4; c++) begin
      ei[16*c +: 16] = adcv[16*int'(cfg[4+4*c +: 2]) +: 16];
      eq[16*c +: 16] = cfg[3] ? 16'h0 : adcv[16*int'(cfg[6+4*c +: 2]) +: 16];
      ew[2*c]   = ei[16*c +: 16];
      ew[2*c+1] = eq[16*c +: 16];
    end
    cnt = int'(cfg[2:0]);
    nw  = (cnt == 1 || cnt == 2 || cnt == 4) ? 2 * cnt : 2;
    if (nw == 2 && cnt != 1) err_exp = 1'b1;
    if (cfg[31:20] != '0) err_exp = 1'b1;
    @(negedge clk);
    adc_bus = adcv; cfg_word = cfg; smp_stb = 1'b1;
    @(negedge clk);
    smp_stb  = 1'b0;
    cfg_word = ~cfg;        // R8: inputs move right after capture
    adc_bus  = ~adcv;
    check("R1 i-bus", ch_i_bus, ei);
    check(cfg[3] ? "R3 zero-q bus" : "R2 q-bus", ch_q_bus, eq);
    check("R10 valid rises", 64'(out_valid), 64'd1);
    k = 0; cyc = 0; prev_r = 1'b1; injected = 1'b0;
    while (k < nw) begin
      check("R10 valid held in burst", 64'(out_valid), 64'd1);
      check(prev_r ? "R4 word order" : "R6 stall hold", 64'(out_data), 64'(ew[k]));
      r = ((cyc + pat) % 3) != 0;
      if (inject && k == 1 && !injected) begin
        smp_stb = 1'b1; injected = 1'b1; ovr_exp = 1'b1;   // R7
      end
      out_ready = r;
      @(negedge clk);
      smp_stb = 1'b0;
      if (r) k++;
      prev_r = r;
      cyc++;
    end
    out_ready = 1'b0;
    check("R10 valid falls", 64'(out_valid), 64'd0);
    check("R7 bus kept after drop", ch_i_bus, ei);
    check("R5 cfg_err", 64'(cfg_err), 64'(err_exp));
    check("R7 ovr_flag", 64'(ovr_flag), 64'(ovr_exp));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int legal_cnt [3];
    int bad_cnt [5];
    legal_cnt = '{1, 2, 4};
    bad_cnt   = '{0, 3, 5, 6, 7};
    n_cmp = 0; n_bad = 0; err_exp = 0; ovr_exp = 0; done = 0;
    rst_n = 1'b0; smp_stb = 1'b0; cfg_word = '0; adc_bus = '0; out_ready = 1'b0;
    repeat (3) @(negedge clk);
    check("R9 valid reset", 64'(out_valid), 64'd0);
    check("R9 err reset", 64'(cfg_err), 64'd0);
    check("R9 ovr reset", 64'(ovr_flag), 64'd0);
    check("R9 i-bus reset", ch_i_bus, 64'd0);
    check("R9 q-bus reset", ch_q_bus, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int ci = 0; ci < 3; ci++)
      for (int z = 0; z < 2; z++)
        for (int p = 0; p < 16; p++)
          run_burst(mk_cfg(legal_cnt[ci], z[0], p), mk_adc(p + 16 * z), p, p == 5);
    // R5: reserved bit set with a legal count
    run_burst(mk_cfg(2, 1'b0, 7) | 32'h0200_0000, mk_adc(40), 7, 1'b0);
    for (int ci = 0; ci < 5; ci++)
      for (int z = 0; z < 2; z++)
        for (int p = 0; p < 4; p++)
          run_burst(mk_cfg(bad_cnt[ci], z[0], p), mk_adc(p + 3 * ci), p, 1'b0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule